// File: doc/BRIEF.md
# Stack and Control-Flow Unit

This unit executes the extended instruction group of a 16-bit processor: stack push and pop, reading the status register into a general register, register-indirect jump, call, return and return-from-interrupt. Each cycle it decodes the presented instruction word and produces the next program counter. It drives a single-port stack memory and a general register file write port. It also owns the stack pointer and a saved interrupt-return address.

A group member has 0x0F as its upper byte. Bits 7:4 give the sub-operation and bits 3:0 name the operand register. The register file sits outside the unit. It supplies the operand register's value and the value of register 15 combinationally. The stack memory answers a read one cycle after it is issued. The fetch logic holds `pc` and `instr` steady while `stall` is high.

The sequencer has two states. ST_IDLE decodes the instruction and acts on it in the same cycle. A POP moves it from ST_IDLE to ST_POP_CAP (transition "issue"). ST_POP_CAP writes the returned data and always goes back to ST_IDLE (transition "capture"). Every other instruction keeps the sequencer in ST_IDLE.

Top module: `stack_flow_unit`

## Requirements
- R1: During and after reset the stack pointer is 0, the saved interrupt-return address is 0, `stall` is 0 and neither memory strobe is active.
- R2: A word whose upper byte is not 0x0F, or a group word with an unused sub-operation (0x2 to 0xA), gives `next_pc = pc + 1` with wrap-around, and raises no register write, no flag write and no memory strobe.
- R3: PUSH (0x0F0r) stores register r at the current stack pointer in the same cycle (`mem_we`=1, `mem_addr`=sp). The stack pointer reads sp+1 after the edge, and `next_pc = pc + 1`.
- R4: POP (0x0F1r) takes two cycles. In the first, `stall`=1, `mem_re`=1, `mem_addr`=sp-1, `next_pc = pc`, and no register is written. In the second, register r is written with `mem_rdata`, the zero flag is written as 1 exactly when that data is 0, `stall`=0 and `next_pc = pc + 1`. The stack pointer reads sp-1 from the second cycle on.
- R5: FSR (0x0FCr) writes `status_in` into register r and gives `next_pc = pc + 1`.
- R6: JMP (0x0FDr) gives `next_pc` equal to the value of register r.
- R7: CALL (0x0FEr) writes pc+1 into register 15 and gives `next_pc` equal to the value of register r.
- R8: RET is exactly 0x0FFF and gives `next_pc` equal to register 15. RETI is exactly 0x0FBF and gives `next_pc` equal to the saved interrupt-return address. Any other word with sub-operation 0xF or 0xB acts as a no-op (`next_pc = pc + 1`, no writes).
- R9: A cycle with `irq_save`=1 loads `irq_pc` into the saved interrupt-return address. This is visible to a RETI from the next cycle on.
- R10: The stack pointer wraps modulo 2^SP_W. A POP at 0 reads address 2^SP_W-1 and leaves the pointer there. A PUSH at 2^SP_W-1 leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 16 | Instruction word, held while stalled |
| pc | input | PC_W | Address of the presented instruction |
| r1_data | input | DATA_W | Value of the register named in bits 3:0 |
| r15_data | input | DATA_W | Value of register 15 |
| status_in | input | DATA_W | Current status register |
| irq_save | input | 1 | Strobe: capture `irq_pc` as the return address |
| irq_pc | input | PC_W | Interrupted program counter |
| next_pc | output | PC_W | Program counter for the following cycle |
| stall | output | 1 | High in the issue cycle of a POP |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | DATA_W | Register file write data |
| zflag_we | output | 1 | Zero-flag update enable |
| zflag_val | output | 1 | New zero-flag value |
| mem_we | output | 1 | Stack memory write strobe |
| mem_re | output | 1 | Stack memory read strobe |
| mem_addr | output | SP_W | Stack memory address |
| mem_wdata | output | DATA_W | Stack memory write data |
| mem_rdata | input | DATA_W | Stack memory read data, one cycle after `mem_re` |
| sp | output | SP_W | Current stack pointer |

## Verification
Several results are due in the same cycle the instruction is presented: `next_pc`, `stall`, the memory strobes with their address and data, and the FSR and CALL register writes. The bench drives each instruction on a falling edge and samples shortly afterwards, before the next rising edge. The stack pointer and the saved return address change at the rising edge, so they are checked in the next sampling window. The POP write lands one cycle later still, in the capture window that follows the issue window. During that capture window the bench keeps the POP word and pc on the inputs, as fetch logic would.

// File: rtl/stack_flow_pkg.sv
package stack_flow_pkg;

    localparam logic [7:0] GROUP_HI  = 8'h0F;
    localparam int         REG_IDX_W = 4;
    localparam logic [3:0] LINK_REG  = 4'hF;
    localparam logic [3:0] FULL_ARG  = 4'hF;

    typedef enum logic [3:0] {
        SUB_PUSH = 4'h0,
        SUB_POP  = 4'h1,
        SUB_RETI = 4'hB,
        SUB_FSR  = 4'hC,
        SUB_JMP  = 4'hD,
        SUB_CALL = 4'hE,
        SUB_RET  = 4'hF
    } sub_op_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PUSH,
        OP_POP,
        OP_FSR,
        OP_JMP,
        OP_CALL,
        OP_RET,
        OP_RETI
    } op_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_POP_CAP
    } seq_state_e;

endpackage

// File: rtl/stack_flow_decode.sv
module stack_flow_decode
    import stack_flow_pkg::*;
(
    input  logic [15:0]          instr,
    output op_kind_e             op,
    output logic [REG_IDX_W-1:0] reg_idx
);

    logic [7:0] hi_byte;
    logic [3:0] sub;

    assign hi_byte = instr[15:8];
    assign sub     = instr[7:4];
    assign reg_idx = instr[3:0];

    always_comb begin
        op = OP_NONE;
        if (hi_byte == GROUP_HI) begin
            unique case (sub)
                SUB_PUSH: op = OP_PUSH;
                SUB_POP:  op = OP_POP;
                SUB_FSR:  op = OP_FSR;
                SUB_JMP:  op = OP_JMP;
                SUB_CALL: op = OP_CALL;
                SUB_RET:  op = (instr[3:0] == FULL_ARG) ? OP_RET  : OP_NONE;
                SUB_RETI: op = (instr[3:0] == FULL_ARG) ? OP_RETI : OP_NONE;
                default:  op = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/stack_flow_seq.sv
module stack_flow_seq
    import stack_flow_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  op_kind_e             op_in,
    input  logic [REG_IDX_W-1:0] idx_in,
    output op_kind_e             op_act,
    output logic                 stall,
    output logic                 cap,
    output logic [REG_IDX_W-1:0] cap_idx
);

    seq_state_e state_q, state_d;
    logic [REG_IDX_W-1:0] idx_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (op_in == OP_POP) state_d = ST_POP_CAP;
            ST_POP_CAP: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && op_in == OP_POP)
                idx_q <= idx_in;
        end
    end

    always_comb begin
        op_act  = OP_NONE;
        stall   = 1'b0;
        cap     = 1'b0;
        cap_idx = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                op_act = op_in;
                stall  = (op_in == OP_POP);
            end
            ST_POP_CAP: begin
                cap = 1'b1;
            end
            default: ;
        endcase
    end

    p_stall_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);
    p_cap_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> cap);

endmodule

// File: rtl/stack_flow_sp.sv
module stack_flow_sp #(
    parameter int SP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    output logic [SP_W-1:0] sp,
    output logic [SP_W-1:0] addr
);

    localparam logic [SP_W-1:0] ONE = SP_W'(1);

    logic [SP_W-1:0] sp_q;
    logic [SP_W-1:0] sp_dec;

    assign sp_dec = sp_q - ONE;
    assign sp     = sp_q;
    assign addr   = pop ? sp_dec : sp_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            sp_q <= '0;
        else if (push)
            sp_q <= sp_q + ONE;
        else if (pop)
            sp_q <= sp_dec;
    end

    p_push_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> sp == $past(sp) + ONE);
    p_pop_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> sp == $past(sp) - ONE);
    p_sp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> $stable(sp));

endmodule

// File: rtl/stack_flow_pcsel.sv
module stack_flow_pcsel
    import stack_flow_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DATA_W = 16
) (
    input  op_kind_e          op,
    input  logic              hold,
    input  logic [PC_W-1:0]   pc,
    input  logic [DATA_W-1:0] r1_data,
    input  logic [DATA_W-1:0] r15_data,
    input  logic [PC_W-1:0]   iret,
    output logic [PC_W-1:0]   next_pc,
    output logic [DATA_W-1:0] link
);

    logic [PC_W-1:0] pc_inc;

    assign pc_inc = pc + PC_W'(1);
    assign link   = DATA_W'(pc_inc);

    always_comb begin
        next_pc = pc_inc;
        if (hold) begin
            next_pc = pc;
        end else begin
            unique case (op)
                OP_JMP, OP_CALL: next_pc = PC_W'(r1_data);
                OP_RET:          next_pc = PC_W'(r15_data);
                OP_RETI:         next_pc = iret;
                default:         next_pc = pc_inc;
            endcase
        end
    end

endmodule

// File: rtl/stack_flow_unit.sv
module stack_flow_unit
    import stack_flow_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DATA_W = 16,
    parameter int SP_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       instr,
    input  logic [PC_W-1:0]   pc,
    input  logic [DATA_W-1:0] r1_data,
    input  logic [DATA_W-1:0] r15_data,
    input  logic [DATA_W-1:0] status_in,
    input  logic              irq_save,
    input  logic [PC_W-1:0]   irq_pc,
    output logic [PC_W-1:0]   next_pc,
    output logic              stall,
    output logic              rf_we,
    output logic [3:0]        rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              zflag_we,
    output logic              zflag_val,
    output logic              mem_we,
    output logic              mem_re,
    output logic [SP_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [SP_W-1:0]   sp
);

    op_kind_e             op_dec, op_act;
    logic [REG_IDX_W-1:0] idx_dec, cap_idx;
    logic                 cap;
    logic [PC_W-1:0]      iret_q;
    logic [DATA_W-1:0]    link;

    stack_flow_decode u_dec (
        .instr   (instr),
        .op      (op_dec),
        .reg_idx (idx_dec)
    );

    stack_flow_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_in   (op_dec),
        .idx_in  (idx_dec),
        .op_act  (op_act),
        .stall   (stall),
        .cap     (cap),
        .cap_idx (cap_idx)
    );

    assign mem_we    = (op_act == OP_PUSH);
    assign mem_re    = (op_act == OP_POP);
    assign mem_wdata = r1_data;

    stack_flow_sp #(.SP_W(SP_W)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (mem_we),
        .pop   (mem_re),
        .sp    (sp),
        .addr  (mem_addr)
    );

    stack_flow_pcsel #(.PC_W(PC_W), .DATA_W(DATA_W)) u_pc (
        .op       (op_act),
        .hold     (stall),
        .pc       (pc),
        .r1_data  (r1_data),
        .r15_data (r15_data),
        .iret     (iret_q),
        .next_pc  (next_pc),
        .link     (link)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            iret_q <= '0;
        else if (irq_save)
            iret_q <= irq_pc;
    end

    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = idx_dec;
        rf_wdata = status_in;
        if (cap) begin
            rf_we    = 1'b1;
            rf_waddr = cap_idx;
            rf_wdata = mem_rdata;
        end else if (op_act == OP_FSR) begin
            rf_we    = 1'b1;
        end else if (op_act == OP_CALL) begin
            rf_we    = 1'b1;
            rf_waddr = LINK_REG;
            rf_wdata = link;
        end
    end

    assign zflag_we  = cap;
    assign zflag_val = (mem_rdata == '0);

    p_mem_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (next_pc == pc && !rf_we));
    p_iret_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_save |=> iret_q == $past(irq_pc));
    p_zflag_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        zflag_we |-> (rf_we && $past(mem_re)));

endmodule

// File: tb/tb_stack_flow_unit.sv
module tb_stack_flow_unit;

    localparam int CLK_PERIOD = 10;
    localparam int PC_W = 16;
    localparam int DATA_W = 16;
    localparam int SP_W = 8;
    localparam int NVEC = 10;

    // {instr, pc, exp_next_pc, exp_we, exp_waddr, exp_wdata}
    localparam logic [68:0] VEC [0:NVEC-1] = '{
        {16'h1234, 16'h0010, 16'h0011, 1'b0, 4'h0, 16'h0000},  // R2 outside group
        {16'h0FD2, 16'h0020, 16'h3202, 1'b0, 4'h0, 16'h0000},  // R6 jump via r2
        {16'h0FE7, 16'h0030, 16'h3707, 1'b1, 4'hF, 16'h0031},  // R7 call via r7
        {16'h0FFF, 16'h0040, 16'h0031, 1'b0, 4'h0, 16'h0000},  // R8 return
        {16'h0FC3, 16'h0050, 16'h0051, 1'b1, 4'h3, 16'h00A5},  // R5 status read
        {16'h0FF3, 16'h0060, 16'h0061, 1'b0, 4'h0, 16'h0000},  // R8 partial ret word
        {16'h0FBF, 16'h0070, 16'h0000, 1'b0, 4'h0, 16'h0000},  // R8 reti after reset
        {16'h0F20, 16'h0080, 16'h0081, 1'b0, 4'h0, 16'h0000},  // R2 unused sub-op
        {16'h0EFF, 16'hFFFF, 16'h0000, 1'b0, 4'h0, 16'h0000},  // R2 pc wrap
        {16'h0FD3, 16'h0000, 16'h00A5, 1'b0, 4'h0, 16'h0000}   // R6 reg after write
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       instr = 16'h0000;
    logic [PC_W-1:0]   pc = '0;
    logic [DATA_W-1:0] status_in = 16'h00A5;
    logic              irq_save = 1'b0;
    logic [PC_W-1:0]   irq_pc = '0;
    logic [DATA_W-1:0] r1_data, r15_data, rf_wdata, mem_wdata, mem_rdata;
    logic [PC_W-1:0]   next_pc;
    logic              stall, rf_we, zflag_we, zflag_val, mem_we, mem_re;
    logic [3:0]        rf_waddr;
    logic [SP_W-1:0]   mem_addr, sp;

    logic [DATA_W-1:0] rf  [0:15];
    logic [DATA_W-1:0] mem [0:(1<<SP_W)-1];

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stack_flow_unit #(.PC_W(PC_W), .DATA_W(DATA_W), .SP_W(SP_W)) dut (
        .clk(clk), .rst_n(rst_n), .instr(instr), .pc(pc),
        .r1_data(r1_data), .r15_data(r15_data), .status_in(status_in),
        .irq_save(irq_save), .irq_pc(irq_pc), .next_pc(next_pc),
        .stall(stall), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .zflag_we(zflag_we), .zflag_val(zflag_val), .mem_we(mem_we),
        .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .sp(sp)
    );

    assign r1_data  = rf[instr[3:0]];
    assign r15_data = rf[15];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) rf[i] <= 16'(16'h3000 + i * 256 + i);
            for (int i = 0; i < (1<<SP_W); i++) mem[i] <= '0;
            mem[(1<<SP_W)-1] <= 16'hBEEF;
            mem_rdata <= '0;
        end else begin
            if (rf_we) rf[rf_waddr] <= rf_wdata;
            if (mem_we) mem[mem_addr] <= mem_wdata;
            if (mem_re) mem_rdata <= mem[mem_addr];
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] w, input logic [PC_W-1:0] p);
        @(negedge clk);
        instr = w;
        pc    = p;
        #1;
    endtask

    task automatic next_window();
        @(negedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "stall in reset", 32'(stall), 0);
        chk("R1", "sp in reset", 32'(sp), 0);
        chk("R1", "strobes in reset", 32'({mem_we, mem_re}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "sp after reset", 32'(sp), 0);

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][68:53], VEC[i][52:37]);
            chk("R2", $sformatf("vec%0d next_pc", i), 32'(next_pc), 32'(VEC[i][36:21]));
            chk("R2", $sformatf("vec%0d rf_we", i), 32'(rf_we), 32'(VEC[i][20]));
            if (VEC[i][20]) begin
                chk("R7", $sformatf("vec%0d waddr", i), 32'(rf_waddr), 32'(VEC[i][19:16]));
                chk("R5", $sformatf("vec%0d wdata", i), 32'(rf_wdata), 32'(VEC[i][15:0]));
            end
            chk("R2", $sformatf("vec%0d mem strobes", i), 32'({mem_we, mem_re, stall, zflag_we}), 0);
        end

        // R3 push r4 then r9
        drive(16'h0F04, 16'h0100);
        chk("R3", "push we", 32'(mem_we), 1);
        chk("R3", "push addr", 32'(mem_addr), 0);
        chk("R3", "push data", 32'(mem_wdata), 32'h3404);
        chk("R3", "push next_pc", 32'(next_pc), 32'h0101);
        drive(16'h0F09, 16'h0101);
        chk("R3", "sp after push", 32'(sp), 1);
        chk("R3", "push2 addr", 32'(mem_addr), 1);
        chk("R3", "push2 data", 32'(mem_wdata), 32'h3909);

        // R4 pop r6: issue then capture
        drive(16'h0F16, 16'h0200);
        chk("R3", "sp after 2 pushes", 32'(sp), 2);
        chk("R4", "issue stall", 32'(stall), 1);
        chk("R4", "issue re", 32'(mem_re), 1);
        chk("R4", "issue addr", 32'(mem_addr), 1);
        chk("R4", "issue next_pc", 32'(next_pc), 32'h0200);
        chk("R4", "issue no rf write", 32'(rf_we), 0);
        next_window();
        chk("R4", "cap stall", 32'(stall), 0);
        chk("R4", "cap re", 32'(mem_re), 0);
        chk("R4", "cap we/idx", 32'({rf_we, rf_waddr}), 32'h16);
        chk("R4", "cap data", 32'(rf_wdata), 32'h3909);
        chk("R4", "cap zflag", 32'({zflag_we, zflag_val}), 32'h2);
        chk("R4", "cap next_pc", 32'(next_pc), 32'h0201);
        chk("R4", "sp after pop", 32'(sp), 1);

        // R4 zero flag set on a zero value
        status_in = 16'h0000;
        drive(16'h0FC8, 16'h0300);
        chk("R5", "fsr zero data", 32'({rf_we, rf_waddr, rf_wdata}), 32'h18_0000);
        drive(16'h0F08, 16'h0301);
        chk("R3", "push zero data", 32'(mem_wdata), 0);
        drive(16'h0F1A, 16'h0302);
        chk("R4", "zero pop addr", 32'(mem_addr), 1);
        next_window();
        chk("R4", "zero pop zflag", 32'({zflag_we, zflag_val}), 32'h3);
        chk("R4", "zero pop dest", 32'({rf_waddr, rf_wdata}), 32'hA_0000);

        // R9 interrupt return capture
        @(negedge clk);
        instr = 16'h0000;
        irq_save = 1'b1;
        irq_pc = 16'h4567;
        drive(16'h0FBF, 16'h0500);
        irq_save = 1'b0;
        #1;
        chk("R9", "reti target", 32'(next_pc), 32'h4567);

        // R10 wrap on pop below zero and push at top
        drive(16'h0F1B, 16'h0600);
        chk("R10", "pop addr 0", 32'(mem_addr), 0);
        next_window();
        chk("R10", "pop data", 32'(rf_wdata), 32'h3404);
        drive(16'h0F1C, 16'h0601);
        chk("R10", "wrap pop addr", 32'(mem_addr), 32'hFF);
        next_window();
        chk("R10", "wrap pop data", 32'(rf_wdata), 32'hBEEF);
        chk("R10", "sp wrapped low", 32'(sp), 32'hFF);
        drive(16'h0F01, 16'h0602);
        chk("R10", "push at top addr", 32'(mem_addr), 32'hFF);
        drive(16'h0000, 16'h0603);
        chk("R10", "sp wrapped high", 32'(sp), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule